// File: doc/BRIEF.md
# Bus Master Security Filter

This block sits on the path from one bus master to a downstream memory port. It rewrites the security attribute of every transaction. For each request it looks at two things: the region attributes that an external attribution unit returns for the request address, and whether the master is configured as secure or non-secure. From these it picks one of four outcomes:

- forward the request as secure;
- forward the request as non-secure;
- block the request with an error response;
- block the request as read-as-zero / write-ignored.

A blocked request never reaches the downstream port, and the block answers it locally. Blocks that end in an error response can raise a sticky interrupt. A separate clear input resets that interrupt and, while held, stops it from being set.

The master side is a single-outstanding valid/ready request channel with a one-cycle response pulse. The downstream side has the same shape and adds a security bit on the request. The attribution lookup is combinational from the request address. The decision and any interrupt set both happen in the cycle the request is accepted.

The two configuration inputs (master is non-secure, blocked accesses answer with an error) are captured into registers every clock cycle. A change therefore governs requests accepted from the next cycle on.

Top module: `master_sec_gate`

## Requirements
- R1: One request is in flight at a time. `mReqReady` is low from acceptance until the response pulse ends. Each accepted request gets exactly one `mRspValid` pulse. A downstream request stays valid until `dReqReady`.
- R2: An address the lookup marks exempt (`lkExempt`=1) is forwarded whatever `lkNonSec` says. `dReqSecure` is 1 when the captured master-non-secure setting is 0, and 0 when it is 1.
- R3: An address marked non-secure and not exempt is forwarded with `dReqSecure`=0, whatever the master configuration.
- R4: An address marked neither exempt nor non-secure is forwarded with `dReqSecure`=1 when the master is configured secure.
- R5: An address marked neither exempt nor non-secure, accessed while the master is configured non-secure, is blocked. No downstream request is issued.
- R6: When the captured error-response setting is 0, a blocked read returns data 0 with `mRspErr`=0. A blocked write is discarded, so downstream memory is unchanged, and also returns `mRspErr`=0. Neither changes `irqOut`.
- R7: When the captured error-response setting is 1, a blocked access returns `mRspErr`=1 with data 0. It sets `irqOut` from the cycle after acceptance if `irqClr` was low at acceptance. `irqOut` then stays high until cleared.
- R8: While `irqClr` is high, `irqOut` reads 0 from the next cycle, and blocked accesses do not set it.
- R9: Reset clears `irqOut` and both captured configuration settings. A request accepted on the first edge after reset is therefore decided as coming from a secure master, even if the configuration inputs were already high.
- R10: A forwarded request carries address, write data, write flag and size unchanged. Size encodes 0=1, 1=2, 2=4 and 3=8 bytes, with byte 0 in bits 7:0 (little-endian lanes). Read data is returned with the lanes at and above the transfer size forced to zero. The downstream error bit is returned as `mRspErr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| cfgMasterNonSec | input | 1 | Master is non-secure (captured each cycle) |
| cfgErrResp | input | 1 | Blocked accesses answer with an error (captured each cycle) |
| irqClr | input | 1 | Clears the interrupt and inhibits setting it while high |
| irqOut | output | 1 | Sticky violation interrupt |
| mReqValid | input | 1 | Master request valid |
| mReqReady | output | 1 | Block can accept a request |
| mReqWrite | input | 1 | 1 = write, 0 = read |
| mReqAddr | input | ADDR_W | Request address |
| mReqWdata | input | DATA_W | Write data, little-endian lanes |
| mReqSize | input | 2 | Transfer size code (log2 bytes) |
| mRspValid | output | 1 | One-cycle response pulse |
| mRspRdata | output | DATA_W | Read data, unused lanes zero |
| mRspErr | output | 1 | Error response |
| lkAddr | output | ADDR_W | Address presented to the attribution unit |
| lkExempt | input | 1 | Address is exempt from checking |
| lkNonSec | input | 1 | Address is in a non-secure region |
| dReqValid | output | 1 | Downstream request valid |
| dReqReady | input | 1 | Downstream accepts request |
| dReqWrite | output | 1 | Downstream write flag |
| dReqAddr | output | ADDR_W | Downstream address |
| dReqWdata | output | DATA_W | Downstream write data |
| dReqSize | output | 2 | Downstream size code |
| dReqSecure | output | 1 | Security attribute: 1 = secure |
| dRspValid | input | 1 | Downstream response pulse |
| dRspRdata | input | DATA_W | Downstream read data |
| dRspErr | input | 1 | Downstream error |

## Verification
The hardest situation to reach is the interplay between the sticky interrupt and its clear input. A blocked error-response access has to land while `irqClr` is held, and it must leave the interrupt low. Then, after release, a later block has to set it again. The bench gets there by raising the interrupt first, holding the clear across a whole blocked transaction, and checking `irqOut` at quiet points between transactions. A second hard case is the reset edge itself. The bench holds the configuration inputs high and keeps a request valid while reset is released, so the very first accepted request exposes the cleared configuration registers. A downstream model with a ready line that varies cycle to cycle checks every forwarded request's attribute and fields. It flags any request that should have been blocked but appears downstream.

// File: rtl/msec_gate_pkg.sv
package msec_gate_pkg;

  typedef enum logic [1:0] {
    ACT_ABORT    = 2'd0,
    ACT_RAZWI    = 2'd1,
    ACT_PASS_SEC = 2'd2,
    ACT_PASS_NS  = 2'd3
  } gate_act_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2,
    ST_RESP  = 2'd3
  } gate_st_e;

  // strobes from control to datapath
  typedef struct packed {
    logic capReq;     // latch master request for forwarding
    logic reqSecure;  // security attribute to attach
    logic capDown;    // latch downstream response
    logic capLocal;   // load a locally generated response
    logic localErr;   // error bit of the local response
  } gate_strobe_t;

  // exempt first, then region, then master configuration
  function automatic gate_act_e resolveAction(input logic exempt,
                                              input logic nonSec,
                                              input logic masterNs,
                                              input logic errResp);
    gate_act_e act;
    if (exempt)         act = masterNs ? ACT_PASS_NS : ACT_PASS_SEC;
    else if (nonSec)    act = ACT_PASS_NS;
    else if (!masterNs) act = ACT_PASS_SEC;
    else if (errResp)   act = ACT_ABORT;
    else                act = ACT_RAZWI;
    return act;
  endfunction

endpackage

// File: rtl/msec_gate_ctrl.sv
module msec_gate_ctrl
  import msec_gate_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         cfgMasterNonSec,
  input  logic         cfgErrResp,
  input  logic         irqClr,
  output logic         irqOut,
  input  logic         mReqValid,
  output logic         mReqReady,
  output logic         mRspValid,
  input  logic         lkExempt,
  input  logic         lkNonSec,
  output logic         dReqValid,
  input  logic         dReqReady,
  input  logic         dRspValid,
  output gate_strobe_t strobe
);

  gate_st_e  state, stateNext;
  gate_act_e act;
  logic      nsQ, errQ, irqQ;
  logic      accept, passNow, blockedNow;

  // captured configuration
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      nsQ  <= 1'b0;
      errQ <= 1'b0;
    end else begin
      nsQ  <= cfgMasterNonSec;
      errQ <= cfgErrResp;
    end
  end

  always_comb begin
    act        = resolveAction(lkExempt, lkNonSec, nsQ, errQ);
    accept     = mReqValid && (state == ST_IDLE);
    passNow    = (act == ACT_PASS_SEC) || (act == ACT_PASS_NS);
    blockedNow = !lkExempt && !lkNonSec && nsQ;
  end

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE:  if (accept)    stateNext = passNow ? ST_ISSUE : ST_RESP;
      ST_ISSUE: if (dReqReady) stateNext = ST_WAIT;
      ST_WAIT:  if (dRspValid) stateNext = ST_RESP;
      ST_RESP:                 stateNext = ST_IDLE;
      default:                 stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    strobe.capReq    = accept && passNow;
    strobe.reqSecure = (act == ACT_PASS_SEC);
    strobe.capDown   = (state == ST_WAIT) && dRspValid;
    strobe.capLocal  = accept && !passNow;
    strobe.localErr  = (act == ACT_ABORT);
  end

  // sticky violation status; clear input has priority
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                            irqQ <= 1'b0;
    else if (irqClr)                      irqQ <= 1'b0;
    else if (accept && act == ACT_ABORT)  irqQ <= 1'b1;
  end

  assign irqOut    = irqQ;
  assign mReqReady = (state == ST_IDLE);
  assign dReqValid = (state == ST_ISSUE);
  assign mRspValid = (state == ST_RESP);

  AST_DS_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    dReqValid && !dReqReady |=> dReqValid);  // R1
  AST_NO_NEW_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    dReqValid |-> !mReqReady);  // R1
  AST_NS_FORWARD: assert property (@(posedge clk) disable iff (!rstN)
    mReqValid && mReqReady && lkNonSec && !lkExempt |=> dReqValid);  // R3
  AST_BLOCK_LOCAL: assert property (@(posedge clk) disable iff (!rstN)
    mReqValid && mReqReady && blockedNow |=> mRspValid && !dReqValid);  // R5
  AST_RAZ_NO_IRQ: assert property (@(posedge clk) disable iff (!rstN)
    mReqValid && mReqReady && blockedNow && !errQ && !irqClr
      |=> irqOut == $past(irqOut));  // R6
  AST_ABORT_IRQ: assert property (@(posedge clk) disable iff (!rstN)
    mReqValid && mReqReady && blockedNow && errQ && !irqClr |=> irqOut);  // R7
  AST_CLR_WINS: assert property (@(posedge clk) disable iff (!rstN)
    irqClr |=> !irqOut);  // R8

endmodule

// File: rtl/msec_gate_datapath.sv
module msec_gate_datapath
  import msec_gate_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  gate_strobe_t      strobe,
  input  logic              mReqWrite,
  input  logic [ADDR_W-1:0] mReqAddr,
  input  logic [DATA_W-1:0] mReqWdata,
  input  logic [1:0]        mReqSize,
  output logic              dReqWrite,
  output logic [ADDR_W-1:0] dReqAddr,
  output logic [DATA_W-1:0] dReqWdata,
  output logic [1:0]        dReqSize,
  output logic              dReqSecure,
  input  logic [DATA_W-1:0] dRspRdata,
  input  logic              dRspErr,
  output logic [DATA_W-1:0] mRspRdata,
  output logic              mRspErr
);

  localparam int LANES = DATA_W / 8;

  logic              writeQ, secQ, rspErrQ;
  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wdataQ, rspDataQ, maskedRdata;
  logic [1:0]        sizeQ;
  logic [4:0]        laneCount;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      writeQ <= 1'b0;
      secQ   <= 1'b0;
      addrQ  <= '0;
      wdataQ <= '0;
      sizeQ  <= '0;
    end else if (strobe.capReq) begin
      writeQ <= mReqWrite;
      secQ   <= strobe.reqSecure;
      addrQ  <= mReqAddr;
      wdataQ <= mReqWdata;
      sizeQ  <= mReqSize;
    end
  end

  // keep only the lanes covered by the transfer size
  assign laneCount = 5'd1 << sizeQ;
  for (genvar g = 0; g < LANES; g++) begin : gLane
    assign maskedRdata[8*g +: 8] = (5'(g) < laneCount) ? dRspRdata[8*g +: 8] : 8'h00;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspDataQ <= '0;
      rspErrQ  <= 1'b0;
    end else if (strobe.capDown) begin
      rspDataQ <= maskedRdata;
      rspErrQ  <= dRspErr;
    end else if (strobe.capLocal) begin
      rspDataQ <= '0;
      rspErrQ  <= strobe.localErr;
    end
  end

  assign dReqWrite  = writeQ;
  assign dReqAddr   = addrQ;
  assign dReqWdata  = wdataQ;
  assign dReqSize   = sizeQ;
  assign dReqSecure = secQ;
  assign mRspRdata  = rspDataQ;
  assign mRspErr    = rspErrQ;

  AST_LOCAL_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capLocal |=> mRspRdata == '0);  // R6
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.capReq |=> $stable(dReqAddr) && $stable(dReqSecure));  // R10

endmodule

// File: rtl/master_sec_gate.sv
module master_sec_gate
  import msec_gate_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgMasterNonSec,
  input  logic              cfgErrResp,
  input  logic              irqClr,
  output logic              irqOut,
  input  logic              mReqValid,
  output logic              mReqReady,
  input  logic              mReqWrite,
  input  logic [ADDR_W-1:0] mReqAddr,
  input  logic [DATA_W-1:0] mReqWdata,
  input  logic [1:0]        mReqSize,
  output logic              mRspValid,
  output logic [DATA_W-1:0] mRspRdata,
  output logic              mRspErr,
  output logic [ADDR_W-1:0] lkAddr,
  input  logic              lkExempt,
  input  logic              lkNonSec,
  output logic              dReqValid,
  input  logic              dReqReady,
  output logic              dReqWrite,
  output logic [ADDR_W-1:0] dReqAddr,
  output logic [DATA_W-1:0] dReqWdata,
  output logic [1:0]        dReqSize,
  output logic              dReqSecure,
  input  logic              dRspValid,
  input  logic [DATA_W-1:0] dRspRdata,
  input  logic              dRspErr
);

  gate_strobe_t strobe;

  assign lkAddr = mReqAddr;

  msec_gate_ctrl uCtrl (
    .clk(clk), .rstN(rstN),
    .cfgMasterNonSec(cfgMasterNonSec), .cfgErrResp(cfgErrResp),
    .irqClr(irqClr), .irqOut(irqOut),
    .mReqValid(mReqValid), .mReqReady(mReqReady), .mRspValid(mRspValid),
    .lkExempt(lkExempt), .lkNonSec(lkNonSec),
    .dReqValid(dReqValid), .dReqReady(dReqReady), .dRspValid(dRspValid),
    .strobe(strobe)
  );

  msec_gate_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .mReqWrite(mReqWrite), .mReqAddr(mReqAddr), .mReqWdata(mReqWdata),
    .mReqSize(mReqSize),
    .dReqWrite(dReqWrite), .dReqAddr(dReqAddr), .dReqWdata(dReqWdata),
    .dReqSize(dReqSize), .dReqSecure(dReqSecure),
    .dRspRdata(dRspRdata), .dRspErr(dRspErr),
    .mRspRdata(mRspRdata), .mRspErr(mRspErr)
  );

endmodule

// File: tb/tb_master_sec_gate.sv
module tb_master_sec_gate;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgMasterNonSec = 1'b0, cfgErrResp = 1'b0, irqClr = 1'b0;
  logic        irqOut;
  logic        mReqValid = 1'b0, mReqWrite = 1'b0;
  logic [31:0] mReqAddr = '0;
  logic [63:0] mReqWdata = '0;
  logic [1:0]  mReqSize = '0;
  logic        mReqReady, mRspValid, mRspErr;
  logic [63:0] mRspRdata;
  logic [31:0] lkAddr;
  logic        lkExempt, lkNonSec;
  logic        dReqValid, dReqWrite, dReqSecure;
  logic        dReqReady = 1'b0, dRspValid = 1'b0, dRspErr = 1'b0;
  logic [31:0] dReqAddr;
  logic [63:0] dReqWdata;
  logic [1:0]  dReqSize;
  logic [63:0] dRspRdata = '0;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  master_sec_gate dut (
    .clk(clk), .rstN(rstN),
    .cfgMasterNonSec(cfgMasterNonSec), .cfgErrResp(cfgErrResp),
    .irqClr(irqClr), .irqOut(irqOut),
    .mReqValid(mReqValid), .mReqReady(mReqReady), .mReqWrite(mReqWrite),
    .mReqAddr(mReqAddr), .mReqWdata(mReqWdata), .mReqSize(mReqSize),
    .mRspValid(mRspValid), .mRspRdata(mRspRdata), .mRspErr(mRspErr),
    .lkAddr(lkAddr), .lkExempt(lkExempt), .lkNonSec(lkNonSec),
    .dReqValid(dReqValid), .dReqReady(dReqReady), .dReqWrite(dReqWrite),
    .dReqAddr(dReqAddr), .dReqWdata(dReqWdata), .dReqSize(dReqSize),
    .dReqSecure(dReqSecure),
    .dRspValid(dRspValid), .dRspRdata(dRspRdata), .dRspErr(dRspErr)
  );

  // attribution map: addr[15:14] 00 secure, 01 non-secure, 1x exempt
  assign lkExempt = lkAddr[15];
  assign lkNonSec = lkAddr[14];

  typedef struct {
    logic [63:0] data;
    logic        err;
    string       tag;
  } rsp_exp_t;

  typedef struct {
    logic        write;
    logic [31:0] addr;
    logic [63:0] wdata;
    logic [1:0]  size;
    logic        secure;
    string       tag;
  } ds_exp_t;

  rsp_exp_t rspQ[$];
  ds_exp_t  dsQ[$];

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // response monitor
  always @(negedge clk) begin
    if (rstN && mRspValid) begin
      if (rspQ.size() == 0) begin
        check("R1 unexpected response", 64'd1, 64'd0);
      end else begin
        rsp_exp_t e;
        e = rspQ.pop_front();
        check({e.tag, " rdata"}, mRspRdata, e.data);
        check({e.tag, " err"}, {63'd0, mRspErr}, {63'd0, e.err});
      end
    end
  end

  // downstream memory model: 64 bytes, errors when addr[13] is set
  logic [7:0] mem [64];
  logic       rspPending = 1'b0;
  logic [63:0] pendData;
  logic       pendErr;
  int         readyCnt = 0;

  always @(negedge clk) begin
    if (!rstN) begin
      dReqReady  = 1'b0;
      dRspValid  = 1'b0;
      rspPending = 1'b0;
    end else begin
      dRspValid = 1'b0;
      dRspRdata = '0;
      dRspErr   = 1'b0;
      if (rspPending) begin
        dRspValid  = 1'b1;
        dRspRdata  = pendData;
        dRspErr    = pendErr;
        rspPending = 1'b0;
      end
      readyCnt++;
      dReqReady = (readyCnt % 3) != 1;
      if (dReqValid && dReqReady) begin
        if (dsQ.size() == 0) begin
          check("R5 unexpected downstream request", 64'd1, 64'd0);
        end else begin
          ds_exp_t d;
          d = dsQ.pop_front();
          check({d.tag, " secure"}, {63'd0, dReqSecure}, {63'd0, d.secure});
          check({d.tag, " R10 addr"}, {32'd0, dReqAddr}, {32'd0, d.addr});
          check({d.tag, " R10 fields"}, {dReqWdata[61:0], dReqWrite, dReqSize[0]} ^ 64'd0,
                {d.wdata[61:0], d.write, d.size[0]});
          check({d.tag, " R10 size"}, {62'd0, dReqSize}, {62'd0, d.size});
        end
        pendErr  = dReqAddr[13];
        pendData = '0;
        if (!pendErr) begin
          if (dReqWrite) begin
            for (int i = 0; i < (1 << dReqSize); i++)
              mem[6'(dReqAddr[5:0] + 6'(i))] = dReqWdata[8*i +: 8];
          end else begin
            for (int i = 0; i < 8; i++)
              pendData[8*i +: 8] = mem[6'(dReqAddr[5:0] + 6'(i))];
          end
        end
        rspPending = 1'b1;
      end
    end
  end

  task automatic expectTxn(input logic wr, input logic [31:0] addr, input logic [63:0] wd,
                           input logic [1:0] sz, input logic pass, input logic sec,
                           input logic [63:0] expData, input logic expErr, input string tag);
    rsp_exp_t r;
    ds_exp_t  d;
    r.data = expData; r.err = expErr; r.tag = tag;
    rspQ.push_back(r);
    if (pass) begin
      d.write = wr; d.addr = addr; d.wdata = wd; d.size = sz; d.secure = sec; d.tag = tag;
      dsQ.push_back(d);
    end
    mReqWrite = wr; mReqAddr = addr; mReqWdata = wd; mReqSize = sz;
  endtask

  task automatic waitIdle();
    while (!mReqReady) @(negedge clk);
  endtask

  task automatic txn(input logic wr, input logic [31:0] addr, input logic [63:0] wd,
                     input logic [1:0] sz, input logic pass, input logic sec,
                     input logic [63:0] expData, input logic expErr, input string tag);
    @(negedge clk);
    waitIdle();
    expectTxn(wr, addr, wd, sz, pass, sec, expData, expErr, tag);
    mReqValid = 1'b1;
    @(negedge clk);
    mReqValid = 1'b0;
    waitIdle();
  endtask

  task automatic setCfg(input logic ns, input logic er);
    @(negedge clk);
    cfgMasterNonSec = ns;
    cfgErrResp      = er;
    repeat (2) @(negedge clk);
  endtask

  task automatic finishRun();
    check("R1 responses outstanding", 64'(rspQ.size()), 64'd0);
    check("R5 downstream outstanding", 64'(dsQ.size()), 64'd0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 8'h00;
    // R9: configuration inputs high through reset, request waiting at release
    cfgMasterNonSec = 1'b1;
    cfgErrResp      = 1'b1;
    repeat (3) @(negedge clk);
    check("R9 irq in reset", {63'd0, irqOut}, 64'd0);
    check("R9 ready in reset", {63'd0, mReqReady}, 64'd1);
    expectTxn(1'b0, 32'h0000_0010, '0, 2'd3, 1'b1, 1'b1, 64'd0, 1'b0, "R9 first request secure");
    mReqValid = 1'b1;
    rstN = 1'b1;
    @(negedge clk);
    mReqValid = 1'b0;
    waitIdle();
    check("R9 irq after first", {63'd0, irqOut}, 64'd0);

    // R4 / R10: secure master, secure region
    setCfg(1'b0, 1'b0);
    txn(1'b1, 32'h0000_0008, 64'h1122_3344_5566_7788, 2'd3, 1'b1, 1'b1, 64'd0, 1'b0, "R4 write");
    txn(1'b0, 32'h0000_0008, '0, 2'd3, 1'b1, 1'b1, 64'h1122_3344_5566_7788, 1'b0, "R4 read");
    txn(1'b0, 32'h0000_0008, '0, 2'd0, 1'b1, 1'b1, 64'h88, 1'b0, "R10 byte read");
    txn(1'b0, 32'h0000_0008, '0, 2'd1, 1'b1, 1'b1, 64'h7788, 1'b0, "R10 half read");
    txn(1'b0, 32'h0000_000C, '0, 2'd2, 1'b1, 1'b1, 64'h1122_3344, 1'b0, "R10 word read");

    // R3 / R2 with secure master
    txn(1'b0, 32'h0000_4008, '0, 2'd3, 1'b1, 1'b0, 64'h1122_3344_5566_7788, 1'b0, "R3 ns region sec master");
    txn(1'b0, 32'h0000_8010, '0, 2'd3, 1'b1, 1'b1, 64'd0, 1'b0, "R2 exempt sec master");
    txn(1'b0, 32'h0000_C010, '0, 2'd3, 1'b1, 1'b1, 64'd0, 1'b0, "R2 exempt over ns");

    // non-secure master
    setCfg(1'b1, 1'b0);
    txn(1'b0, 32'h0000_8010, '0, 2'd3, 1'b1, 1'b0, 64'd0, 1'b0, "R2 exempt ns master");
    txn(1'b0, 32'h0000_4008, '0, 2'd3, 1'b1, 1'b0, 64'h1122_3344_5566_7788, 1'b0, "R3 ns region ns master");

    // R5 / R6: blocked read-as-zero / write-ignored
    txn(1'b1, 32'h0000_0008, 64'hFFFF_FFFF_FFFF_FFFF, 2'd3, 1'b0, 1'b0, 64'd0, 1'b0, "R6 blocked write");
    check("R6 irq after blocked write", {63'd0, irqOut}, 64'd0);
    txn(1'b0, 32'h0000_0008, '0, 2'd3, 1'b0, 1'b0, 64'd0, 1'b0, "R5 R6 blocked read");
    check("R6 irq after blocked read", {63'd0, irqOut}, 64'd0);
    setCfg(1'b0, 1'b0);
    txn(1'b0, 32'h0000_0008, '0, 2'd3, 1'b1, 1'b1, 64'h1122_3344_5566_7788, 1'b0, "R6 write was ignored");

    // R7: blocked with error response, sticky interrupt
    setCfg(1'b1, 1'b1);
    txn(1'b0, 32'h0000_0000, '0, 2'd3, 1'b0, 1'b0, 64'd0, 1'b1, "R7 abort read");
    check("R7 irq set", {63'd0, irqOut}, 64'd1);
    txn(1'b0, 32'h0000_8010, '0, 2'd3, 1'b1, 1'b0, 64'd0, 1'b0, "R7 pass after abort");
    check("R7 irq sticky", {63'd0, irqOut}, 64'd1);

    // R8: clear input forces low and inhibits setting
    @(negedge clk);
    irqClr = 1'b1;
    repeat (2) @(negedge clk);
    check("R8 irq cleared", {63'd0, irqOut}, 64'd0);
    txn(1'b1, 32'h0000_0000, 64'h55, 2'd0, 1'b0, 1'b0, 64'd0, 1'b1, "R8 abort while clear held");
    check("R8 irq inhibited", {63'd0, irqOut}, 64'd0);
    @(negedge clk);
    irqClr = 1'b0;
    repeat (2) @(negedge clk);
    check("R8 irq stays low after release", {63'd0, irqOut}, 64'd0);
    txn(1'b0, 32'h0000_0000, '0, 2'd3, 1'b0, 1'b0, 64'd0, 1'b1, "R7 abort after release");
    check("R7 irq set again", {63'd0, irqOut}, 64'd1);

    // R10: downstream error and partial write
    setCfg(1'b0, 1'b0);
    txn(1'b0, 32'h0000_6000, '0, 2'd3, 1'b1, 1'b0, 64'd0, 1'b1, "R10 downstream error");
    txn(1'b1, 32'h0000_4020, 64'hFFFF_FFFF_FFFF_ABCD, 2'd1, 1'b1, 1'b0, 64'd0, 1'b0, "R10 half write");
    txn(1'b0, 32'h0000_4020, '0, 2'd3, 1'b1, 1'b0, 64'h0000_0000_0000_ABCD, 1'b0, "R10 half write lanes");

    repeat (4) @(negedge clk);
    finishRun();
  end

endmodule